// File: doc/BRIEF.md
# One-Wire Search Accelerator Slot Engine

This block drives the time slots of a single-wire bus master. It has two modes. In plain mode, one host byte becomes eight slots, least-significant bit first. Each slot both writes the bit and samples the bus. The byte that comes back is the bus level seen in each slot, which is the wired-AND of the master and any responding slave. Reading a byte is therefore done by sending all ones.

In search mode, a 64-bit device identifier is resolved four bits per host byte. For each identifier bit, the engine runs two read slots: the true value and then its complement. It then runs one write slot carrying the direction it chose. The host first sends the search command as a plain byte. It then sets `search_mode` and exchanges sixteen bytes. Afterwards it returns to plain mode and resets the bus.

Each response byte interleaves direction bits and discrepancy flags. The host rebuilds the identifier from the direction bits, least-significant nibble first.

Top module: `owsearch_accel`

## Requirements
- R1: After reset, `busy` and `rx_full` are 0 and `bus_pull` is released (0).
- R2: A plain-mode byte runs 8 slots, bit 0 first. Received bit n is the bus level sampled in slot n, so the received byte equals the sent byte ANDed with the byte a slave drives.
- R3: A slot writing 0 holds `bus_pull` high for LOW0_LEN cycles (10 by default). A slot writing 1, and every read slot, holds it for LOW1_LEN cycles (2 by default). Each slot lasts SLOT_LEN cycles.
- R4: A search-mode byte runs 12 slots: for each of 4 identifier bits, a true-read slot, a complement-read slot and a write slot carrying the chosen direction.
- R5: In a search response, bit 2k+1 is the chosen direction and bit 2k is the discrepancy flag of the k-th identifier bit of that byte (k = 0..3).
- R6: When the true and complement reads are both 0, the flag is 1 and the direction is bit 2k+1 of the sent byte.
- R7: When exactly one of the two reads is 1, the flag is 0 and the direction equals the true read.
- R8: When both reads are 1 (no device answering), the flag is 1 and the direction is 1.
- R9: Sixteen search bytes resolve a full identifier. The direction bits of byte j form identifier bits 4j..4j+3, so the identifier is assembled least-significant first.
- R10: `rx_full` rises when the last slot of a byte ends, with `rx_data` holding the result. It stays set until `rx_ack`, which clears it.
- R11: `tx_valid` is ignored while `busy` is 1.
- R12: The mode is taken from `search_mode` when a byte is accepted. Changing it while busy has no effect on that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| search_mode | input | 1 | Selects search mode for the next accepted byte |
| tx_valid | input | 1 | Starts a byte when the engine is idle |
| tx_data | input | 8 | Byte to send, or search preference bits (odd positions) |
| busy | output | 1 | Slots in progress |
| rx_data | output | 8 | Received byte or search response |
| rx_full | output | 1 | Result waiting |
| rx_ack | input | 1 | Clears `rx_full` |
| bus_pull | output | 1 | 1 pulls the bus low (open-drain drive) |
| bus_in | input | 1 | Sampled bus level |

## Verification
The bench places two identifiers on a modelled bus. The identifiers differ in their lowest and highest bits, so the lowest bit produces a real both-zero conflict. A design that ignored the preference bit would find the same device whichever preference is sent. A swapped flag and direction layout would scramble every response byte.

An empty bus exercises the both-ones case, which must return all-ones bytes. A design that wrote 0 there, or cleared the flag, would show up at once.

Slot counts per byte and the pulse width of each slot type are measured, which catches a missing write slot or wrong slot timing. The bench also pulses `tx_valid` and toggles the mode while a byte is in progress. A design that restarted, or switched mode part-way through a byte, would corrupt the result.

// File: rtl/owsearch_accel.sv
module owsearch_accel #(
  parameter int SLOT_LEN  = 16,
  parameter int LOW0_LEN  = 10,
  parameter int LOW1_LEN  = 2,
  parameter int SAMPLE_AT = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       search_mode,
  input  logic       tx_valid,
  input  logic [7:0] tx_data,
  output logic       busy,
  output logic [7:0] rx_data,
  output logic       rx_full,
  input  logic       rx_ack,
  output logic       bus_pull,
  input  logic       bus_in
);
  localparam int CW = $clog2(SLOT_LEN + 1);

  logic          srch;
  logic [7:0]    txb, acc;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [1:0]    ph;
  logic          rd_true, dir_q;

  wire wbit     = !srch ? txb[bitn] : (ph == 2'd2 ? dir_q : 1'b1);
  wire sample   = busy && cnt == CW'(SAMPLE_AT);
  wire slot_end = busy && cnt == CW'(SLOT_LEN - 1);
  wire last     = srch ? (bitn == 3'd3 && ph == 2'd2) : (bitn == 3'd7);
  wire both0    = !rd_true && !bus_in;
  wire both1    = rd_true && bus_in;
  wire pick     = both0 ? txb[{bitn[1:0], 1'b1}] : rd_true;
  wire flag     = both0 || both1;

  assign bus_pull = busy && (cnt < (wbit ? CW'(LOW1_LEN) : CW'(LOW0_LEN)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      srch    <= 1'b0;
      txb     <= '0;
      acc     <= '0;
      cnt     <= '0;
      bitn    <= '0;
      ph      <= '0;
      rd_true <= 1'b0;
      dir_q   <= 1'b0;
      rx_data <= '0;
      rx_full <= 1'b0;
    end else begin
      if (rx_ack) rx_full <= 1'b0;
      if (!busy) begin
        if (tx_valid) begin
          busy <= 1'b1;
          srch <= search_mode;
          txb  <= tx_data;
          acc  <= '0;
          cnt  <= '0;
          bitn <= '0;
          ph   <= '0;
        end
      end else begin
        cnt <= cnt + 1'b1;
        if (sample) begin
          if (!srch) acc[bitn] <= bus_in;
          else if (ph == 2'd0) rd_true <= bus_in;
          else if (ph == 2'd1) begin
            dir_q <= pick;
            acc[{bitn[1:0], 1'b1}] <= pick;
            acc[{bitn[1:0], 1'b0}] <= flag;
          end
        end
        if (slot_end) begin
          cnt <= '0;
          if (last) begin
            busy    <= 1'b0;
            rx_data <= acc;
            rx_full <= 1'b1;
          end else if (!srch) begin
            bitn <= bitn + 1'b1;
          end else if (ph == 2'd2) begin
            ph   <= 2'd0;
            bitn <= bitn + 1'b1;
          end else begin
            ph <= ph + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/owsearch_accel_chk.sv
module owsearch_accel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       search_mode,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       busy,
  input logic [7:0] rx_data,
  input logic       rx_full,
  input logic       rx_ack,
  input logic       bus_pull,
  input logic       bus_in
);
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_pull); // R1
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && tx_valid) |=> busy); // R2
  AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rx_full); // R10
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ack && !busy) |=> !rx_full); // R10
  AST_RXDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(rx_data)); // R10
endmodule

bind owsearch_accel owsearch_accel_chk chk (.*);

// File: tb/owsearch_accel_test.sv
module owsearch_accel_test;
  logic clk = 0, rst_n = 0;
  logic search_mode = 0, tx_valid = 0, rx_ack = 0;
  logic [7:0] tx_data = 0;
  logic busy, rx_full, bus_pull, bus_in;
  logic [7:0] rx_data;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  logic slave_low = 0;
  assign bus_in = !(bus_pull || slave_low);

  owsearch_accel uut (.*);

  localparam logic [63:0] ID_A = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] ID_B = 64'h8123_4567_89AB_CDEE;

  // slave model
  logic smode = 0, act_a = 0, act_b = 0, prev = 0;
  logic [7:0] sbyte = 8'hFF;
  logic [2:0] snb = 0;
  logic [1:0] sph = 0;
  logic [5:0] gbit = 0;
  int scnt = 100, slots = 0, run = 0, lastlen = 0;
  logic t, c;

  always @(posedge clk) begin
    prev <= bus_pull;
    if (bus_pull) run <= run + 1;
    else if (prev) begin lastlen <= run; run <= 0; end
    if (bus_pull && !prev) begin
      scnt <= 0;
      slots <= slots + 1;
      t = (!act_a || ID_A[gbit]) && (!act_b || ID_B[gbit]);
      c = (!act_a || !ID_A[gbit]) && (!act_b || !ID_B[gbit]);
      if (!smode) slave_low <= !sbyte[snb];
      else if (sph == 0) slave_low <= !t;
      else if (sph == 1) slave_low <= !c;
      else slave_low <= 0;
    end else scnt <= scnt + 1;
    if (scnt == 12) slave_low <= 0;
    if (scnt == 6 && smode && sph == 2) begin
      if (ID_A[gbit] != !bus_pull) act_a <= 0;
      if (ID_B[gbit] != !bus_pull) act_b <= 0;
      gbit <= gbit + 1;
    end
    if (scnt == 13) begin
      if (!smode) snb <= snb + 1;
      else sph <= (sph == 2) ? 2'd0 : sph + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic m, input logic [7:0] d);
    @(negedge clk);
    while (busy) @(negedge clk);
    search_mode = m; tx_data = d; tx_valid = 1;
    @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic collect(output logic [7:0] r);
    while (!rx_full) @(negedge clk);
    r = rx_data;
    rx_ack = 1;
    @(negedge clk);
    rx_ack = 0;
  endtask

  task automatic xfer(input logic m, input logic [7:0] d, output logic [7:0] r);
    send(m, d);
    collect(r);
  endtask

  function automatic logic [127:0] ref_rsp(input logic [1:0] nd, input logic [63:0] pref);
    logic aa, ab, tt, cc, dir, fl;
    logic [127:0] r = '0;
    aa = nd >= 1; ab = nd >= 2;
    for (int i = 0; i < 64; i++) begin
      tt = 1; cc = 1;
      if (aa) begin tt &= ID_A[i]; cc &= !ID_A[i]; end
      if (ab) begin tt &= ID_B[i]; cc &= !ID_B[i]; end
      if (!tt && !cc) begin fl = 1; dir = pref[i]; end
      else if (tt && cc) begin fl = 1; dir = 1; end
      else begin fl = 0; dir = tt; end
      if (ID_A[i] != dir) aa = 0;
      if (ID_B[i] != dir) ab = 0;
      r[8*(i/4) + 2*(i%4) + 1] = dir;
      r[8*(i/4) + 2*(i%4)] = fl;
    end
    return r;
  endfunction

  task automatic search(input logic [1:0] nd, input logic [63:0] pref, output logic [63:0] id);
    logic [7:0] r, pb;
    logic [127:0] exp;
    int s0;
    exp = ref_rsp(nd, pref);
    smode = 0; sbyte = 8'hFF;
    xfer(0, 8'hF0, r);
    act_a = nd >= 1; act_b = nd >= 2; gbit = 0; sph = 0; smode = 1;
    id = '0;
    for (int j = 0; j < 16; j++) begin
      pb = '0;
      for (int k = 0; k < 4; k++) pb[2*k+1] = pref[4*j+k];
      s0 = slots;
      xfer(1, pb, r);
      check(r == exp[8*j +: 8], "R5 R6 R7 R8 response byte", r, exp[8*j +: 8]);
      if (j == 0) check(slots - s0 == 12, "R4 slots per search byte", slots - s0, 12);
      for (int k = 0; k < 4; k++) id[4*j+k] = r[2*k+1];
    end
    smode = 0;
  endtask

  localparam int NV = 6;
  localparam logic [23:0] VEC [NV] = '{
    {8'hFF, 8'hA5, 8'hA5}, {8'h3C, 8'hFF, 8'h3C}, {8'hFF, 8'h00, 8'h00},
    {8'hF0, 8'h0F, 8'h00}, {8'hC3, 8'hF5, 8'hC1}, {8'h81, 8'hFF, 8'h81}};

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic [63:0] id;
    int s0;
    repeat (3) @(negedge clk);
    check(!busy && !rx_full && !bus_pull, "R1 reset state", {busy, rx_full, bus_pull}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      sbyte = VEC[v][15:8];
      s0 = slots;
      xfer(0, VEC[v][23:16], r);
      check(r == VEC[v][7:0], "R2 plain byte", r, VEC[v][7:0]);
      if (v == 0) check(slots - s0 == 8, "R2 slots per plain byte", slots - s0, 8);
    end
    sbyte = 8'hFF;

    xfer(0, 8'h00, r);
    repeat (2) @(negedge clk);
    check(lastlen == 10, "R3 write-0 low time", lastlen, 10);
    xfer(0, 8'hFF, r);
    repeat (2) @(negedge clk);
    check(lastlen == 2, "R3 write-1 low time", lastlen, 2);

    // R11 and R12: stray start and mode change while busy
    s0 = slots;
    send(0, 8'h3C);
    repeat (40) @(negedge clk);
    search_mode = 1; tx_data = 8'h00; tx_valid = 1;
    @(negedge clk);
    tx_valid = 0;
    collect(r);
    check(r == 8'h3C, "R11 start ignored while busy", r, 8'h3C);
    check(slots - s0 == 8, "R12 mode held for the byte", slots - s0, 8);
    repeat (40) @(negedge clk);
    check(!busy && slots - s0 == 8, "R11 no extra byte started", slots - s0, 8);

    // R10: flag held until ack
    send(0, 8'h55);
    while (!rx_full) @(negedge clk);
    repeat (20) @(negedge clk);
    check(rx_full && rx_data == 8'h55, "R10 result held without ack", {rx_full, rx_data}, {1'b1, 8'h55});
    rx_ack = 1; @(negedge clk); rx_ack = 0;
    check(!rx_full, "R10 ack clears flag", rx_full, 0);

    search(2, 64'h0, id);
    check(id == ID_B, "R9 R6 prefer-0 finds B", id, ID_B);
    search(2, ~64'h0, id);
    check(id == ID_A, "R9 R6 prefer-1 finds A", id, ID_A);
    search(1, 64'h0, id);
    check(id == ID_A, "R9 R7 single device", id, ID_A);
    search(0, 64'h0, id);
    check(id == ~64'h0, "R8 empty bus", id, ~64'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule